// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank DDR SDRAM command bus. On every rising clock edge it samples chip select, the three active-low command lines, the row/column address bus, the bank address and clock enable. It turns legal combinations into a one-cycle command strobe. The strobe carries the command code, the bank, the row or column address, an auto-precharge flag and a precharge-all flag.

Alongside the decode, the block keeps a model of each bank: whether the bank is open and which row it holds. Bank state changes on activate, precharge and the delayed close that auto-precharge requests. Illegal sequences raise a protocol-error flag and leave the bank model untouched. Clock enable drives a small power state machine that reports power-down or self-refresh. It also flags any clock-enable level that was not held for a full cycle.

Address bit 10 has more than one role. On a precharge it selects between all banks and one bank. On a read or write it requests auto-precharge, and it is also skipped when the column address is formed. All outputs are registered and appear one clock after the sampling edge.

Top module: `sdcmd_tracker`

## Requirements
- R1: With cs_n low and cke high at both the current and the previous sampling edge, {ras_n,cas_n,we_n} = 011, 101, 100, 010 and 001 produce cmd_vld_o = 1 with cmd_o = 1 (activate), 2 (read), 3 (write), 4 (precharge) and 5 (refresh). The outputs appear one cycle after the sampling edge. Every other code, including 111, 110 and 000, produces no strobe.
- R2: While cs_n is high, no strobe is produced and no bank state changes. An auto-precharge countdown that is already running keeps counting.
- R3: An accepted activate sets the addressed bit of open_mask_o and stores the full 13-bit address as that bank's row, visible at open_rows_o[13*b +: 13]. addr_o echoes the row.
- R4: For a read or write, addr_o = {2'b00, A11, A9..A0}. A10 and A12 do not appear in it.
- R5: A precharge with A10 high closes every bank and sets preall_o. With A10 low it closes only the addressed bank and preall_o is 0. A precharge to a closed bank is not an error.
- R6: A read or write with A10 high sets autopre_o and closes its bank BURST_LEN clock edges after the command edge. With A10 low the bank stays open.
- R7: The bank index is ba with ba[0] as the low bit, so ba = 2'b01 addresses bank 1 and ba = 2'b10 addresses bank 2. bank_o reports it.
- R8: A read or write to a closed bank, or to a bank with an auto-precharge pending, and an activate to an open bank, produce the strobe with proto_err_o = 1 and change no bank state.
- R9: cke sampled low after a high sample enters power-down (pwrdn_o = 1), or self-refresh (selfref_o = 1, pwrdn_o = 0) when a refresh code is presented with cs_n low on that edge. The state holds while cke stays low, and both outputs clear after the first edge that samples cke high.
- R10: No command is decoded and no bank state changes on any edge that samples cke low, nor on the first edge that samples cke high again.
- R11: If cke changes at one edge and changes back at the next, cke_viol_o is 1 for one cycle after the second edge. A level held for at least one full cycle never sets it.
- R12: After reset, cmd_vld_o, proto_err_o, open_mask_o, pwrdn_o, selfref_o and cke_viol_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command line, active low |
| cas_n | input | 1 | Column strobe command line, active low |
| we_n | input | 1 | Write-enable command line, active low |
| addr_i | input | 13 | Row / column address, bit 10 overloaded |
| ba_i | input | 2 | Bank address, bit 0 is the low bit |
| cke | input | 1 | Clock enable |
| cmd_vld_o | output | 1 | One-cycle decoded command strobe |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 2 | Bank addressed by the command |
| addr_o | output | 13 | Row (activate) or column (read/write) |
| autopre_o | output | 1 | Read/write requested auto-precharge |
| preall_o | output | 1 | Precharge targeted all banks |
| proto_err_o | output | 1 | Command illegal for current bank state |
| open_mask_o | output | 4 | One bit per open bank |
| open_rows_o | output | 52 | Row held by each bank, 13 bits per bank |
| pwrdn_o | output | 1 | Power-down active |
| selfref_o | output | 1 | Self-refresh active |
| cke_viol_o | output | 1 | Clock-enable hold violation |

## Verification
A wrong bank model shows on open_mask_o and open_rows_o one cycle after the command that corrupts it. A missed state change also shows later, through proto_err_o on the next read, write or activate to that bank. A countdown that is off by one moves the auto-precharge close by one cycle, so the bench samples the mask on the edges just before and just after BURST_LEN. A power-state error shows at once as a strobe that should have been suppressed, or as a missing one after the exit edge.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_REF  = 3'd5
    } op_e;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic en_i,
    output op_e  op_o
);
    always_comb begin
        op_o = OP_NONE;
        if (en_i && !cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  op_o = OP_ACT;
                3'b101:  op_o = OP_RD;
                3'b100:  op_o = OP_WR;
                3'b010:  op_o = OP_PRE;
                3'b001:  op_o = OP_REF;
                default: op_o = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank #(
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             ap_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic             pend_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
        logic [ROW_W-1:0] row;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (st_q.cnt == CNT_W'(1)) begin
            st_d.open = 1'b0;
        end
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.row  = row_i;
        end
        if (ap_i) begin
            st_d.cnt = CNT_W'(BURST_LEN);
        end
        if (close_i) begin
            st_d.open = 1'b0;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;
    assign pend_o = (st_q.cnt != '0);
    assign row_o  = st_q.row;

    // R6
    ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(1) && !act_i) |=> !st_q.open);

    // R6
    ap_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_i && !close_i) |=> (pend_o && open_o));

    // R3
    act_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && !close_i) |=> (st_q.open && st_q.row == $past(row_i)));
endmodule

// File: rtl/sdcmd_cke.sv
module sdcmd_cke (
    input  logic clk,
    input  logic rst_n,
    input  logic cke_i,
    input  logic ref_i,
    output logic active_o,
    output logic pwrdn_o,
    output logic selfref_o,
    output logic viol_o
);
    typedef struct packed {
        logic cke;
        logic chg;
        logic pd;
        logic sr;
        logic viol;
    } cke_t;

    cke_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cke  = cke_i;
        st_d.chg  = (cke_i != st_q.cke);
        st_d.viol = st_q.chg && (cke_i != st_q.cke);
        if (!cke_i) begin
            if (st_q.cke) begin
                st_d.sr = ref_i;
                st_d.pd = !ref_i;
            end
        end else begin
            st_d.pd = 1'b0;
            st_d.sr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cke: 1'b1, chg: 1'b0, pd: 1'b0, sr: 1'b0, viol: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o  = cke_i && st_q.cke;
    assign pwrdn_o   = st_q.pd;
    assign selfref_o = st_q.sr;
    assign viol_o    = st_q.viol;

    // R9
    pd_sr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.pd && st_q.sr));

    // R9
    low_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cke |-> (st_q.pd || st_q.sr));

    // R11
    viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.viol |-> st_q.chg);
endmodule

// File: rtl/sdcmd_tracker.sv
module sdcmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [ROW_W-1:0]           addr_i,
    input  logic [BA_W-1:0]            ba_i,
    input  logic                       cke,
    output logic                       cmd_vld_o,
    output logic [2:0]                 cmd_o,
    output logic [BA_W-1:0]            bank_o,
    output logic [ROW_W-1:0]           addr_o,
    output logic                       autopre_o,
    output logic                       preall_o,
    output logic                       proto_err_o,
    output logic [NUM_BANKS-1:0]       open_mask_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows_o,
    output logic                       pwrdn_o,
    output logic                       selfref_o,
    output logic                       cke_viol_o
);
    localparam int AP_BIT = 10;
    localparam int COL_W  = 11;

    typedef struct packed {
        logic             vld;
        op_e              op;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] addr;
        logic             ap;
        logic             pall;
        logic             err;
    } out_t;

    out_t out_d, out_q;

    logic                 active;
    logic                 ref_raw;
    op_e                  op;
    logic [NUM_BANKS-1:0] open_v, pend_v;
    logic [NUM_BANKS-1:0] act_v, ap_v, close_v;
    logic [ROW_W-1:0]     rows_v [NUM_BANKS];
    logic                 is_rdwr, err, a10;
    logic [ROW_W-1:0]     col;

    assign ref_raw = !cs_n && ({ras_n, cas_n, we_n} == 3'b001);
    assign a10     = addr_i[AP_BIT];
    assign col     = {{(ROW_W-COL_W){1'b0}}, addr_i[11], addr_i[9:0]};

    sdcmd_cke u_cke (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_i     (cke),
        .ref_i     (ref_raw),
        .active_o  (active),
        .pwrdn_o   (pwrdn_o),
        .selfref_o (selfref_o),
        .viol_o    (cke_viol_o)
    );

    sdcmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .en_i  (active),
        .op_o  (op)
    );

    always_comb begin
        is_rdwr = (op == OP_RD) || (op == OP_WR);
        err     = ((op == OP_ACT) && open_v[ba_i])
               || (is_rdwr && (!open_v[ba_i] || pend_v[ba_i]));
        out_d      = '0;
        out_d.vld  = (op != OP_NONE);
        out_d.op   = op;
        out_d.bank = ba_i;
        out_d.err  = err;
        case (op)
            OP_ACT: out_d.addr = addr_i;
            OP_RD, OP_WR: begin
                out_d.addr = col;
                out_d.ap   = a10;
            end
            OP_PRE: out_d.pall = a10;
            default: out_d.addr = '0;
        endcase
        for (int b = 0; b < NUM_BANKS; b++) begin
            act_v[b]   = (op == OP_ACT) && !err && (ba_i == BA_W'(b));
            ap_v[b]    = is_rdwr && a10 && !err && (ba_i == BA_W'(b));
            close_v[b] = (op == OP_PRE) && (a10 || (ba_i == BA_W'(b)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdcmd_bank #(
            .ROW_W     (ROW_W),
            .BURST_LEN (BURST_LEN)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_i   (act_v[g]),
            .ap_i    (ap_v[g]),
            .close_i (close_v[g]),
            .row_i   (addr_i),
            .open_o  (open_v[g]),
            .pend_o  (pend_v[g]),
            .row_o   (rows_v[g])
        );
        assign open_rows_o[g*ROW_W +: ROW_W] = rows_v[g];
    end

    assign cmd_vld_o   = out_q.vld;
    assign cmd_o       = out_q.op;
    assign bank_o      = out_q.bank;
    assign addr_o      = out_q.addr;
    assign autopre_o   = out_q.ap;
    assign preall_o    = out_q.pall;
    assign proto_err_o = out_q.err;
    assign open_mask_o = open_v;

    // R5
    pall_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preall_o |-> (open_mask_o == '0));

    // R8
    err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err_o && ($past(pend_v) == '0)) |-> $stable(open_mask_o));

    // R10
    no_cmd_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn_o || selfref_o) |-> !cmd_vld_o);

    // R3
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o && cmd_o == 3'd1 && !proto_err_o) |-> open_mask_o[bank_o]);
endmodule

// File: tb/sim_sdcmd_tracker.sv
module sim_sdcmd_tracker;
    localparam int BL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr_i = '0;
    logic [1:0]  ba_i = '0;
    logic        cke = 1'b1;
    logic        cmd_vld_o, autopre_o, preall_o, proto_err_o;
    logic [2:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [12:0] addr_o;
    logic [3:0]  open_mask_o;
    logic [51:0] open_rows_o;
    logic        pwrdn_o, selfref_o, cke_viol_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdcmd_tracker #(.BURST_LEN(BL)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr_i(addr_i), .ba_i(ba_i), .cke(cke),
        .cmd_vld_o(cmd_vld_o), .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o),
        .autopre_o(autopre_o), .preall_o(preall_o), .proto_err_o(proto_err_o),
        .open_mask_o(open_mask_o), .open_rows_o(open_rows_o),
        .pwrdn_o(pwrdn_o), .selfref_o(selfref_o), .cke_viol_o(cke_viol_o)
    );

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                           C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic cs, input logic [2:0] code, input logic [1:0] b,
                         input logic [12:0] a, input logic ck);
        @(negedge clk);
        cs_n = cs; {ras_n, cas_n, we_n} = code; ba_i = b; addr_i = a; cke = ck;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R12 vld", cmd_vld_o, 0);
        check("R12 mask", open_mask_o, 0);
        check("R12 err", proto_err_o, 0);
        check("R12 power", {pwrdn_o, selfref_o, cke_viol_o}, 0);
    endtask

    task automatic t_activate();
        issue(0, C_ACT, 2'b10, 13'h1ABC, 1);
        check("R1 act strobe", {cmd_vld_o, cmd_o}, {1'b1, 3'd1});
        check("R7 bank2", bank_o, 2);
        check("R3 act addr", addr_o, 13'h1ABC);
        check("R3 mask", open_mask_o, 4'b0100);
        check("R3 row", open_rows_o[26 +: 13], 13'h1ABC);
        issue(0, C_ACT, 2'b01, 13'h0055, 1);
        check("R7 bank1", bank_o, 1);
        check("R7 mask", open_mask_o, 4'b0110);
        check("R3 row1", open_rows_o[13 +: 13], 13'h0055);
    endtask

    task automatic t_rdwr();
        issue(0, C_RD, 2'b10, 13'h1AA5, 1);
        check("R1 rd strobe", {cmd_vld_o, cmd_o, proto_err_o}, {1'b1, 3'd2, 1'b0});
        check("R4 rd col", addr_o, 13'h06A5);
        check("R6 no ap", autopre_o, 0);
        issue(0, C_WR, 2'b01, 13'h0803, 1);
        check("R1 wr strobe", {cmd_vld_o, cmd_o}, {1'b1, 3'd3});
        check("R4 wr col", addr_o, 13'h0403);
        check("R6 stays open", open_mask_o, 4'b0110);
    endtask

    task automatic t_errors();
        issue(0, C_RD, 2'b00, 13'h0001, 1);
        check("R8 rd closed", {cmd_vld_o, proto_err_o}, 2'b11);
        check("R8 mask kept", open_mask_o, 4'b0110);
        issue(0, C_ACT, 2'b10, 13'h0F0F, 1);
        check("R8 act open", proto_err_o, 1);
        check("R8 row kept", open_rows_o[26 +: 13], 13'h1ABC);
        issue(1, C_ACT, 2'b00, 13'h0123, 1);
        check("R2 cs high", {cmd_vld_o, open_mask_o}, {1'b0, 4'b0110});
    endtask

    task automatic t_autopre();
        issue(0, C_RD, 2'b10, 13'h1EA5, 1);
        check("R6 ap flag", {autopre_o, addr_o}, {1'b1, 13'h06A5});
        issue(0, C_RD, 2'b10, 13'h0000, 1);
        check("R8 pending", proto_err_o, 1);
        issue(1, C_ACT, 2'b10, 13'h0000, 1);
        check("R2 count runs", {cmd_vld_o, open_mask_o}, {1'b0, 4'b0110});
        issue(1, C_ACT, 2'b10, 13'h0000, 1);
        check("R6 edge BL-1", open_mask_o, 4'b0110);
        issue(1, C_NOP, 2'b10, 13'h0000, 1);
        check("R6 edge BL", open_mask_o, 4'b0010);
    endtask

    task automatic t_precharge();
        issue(0, C_ACT, 2'b00, 13'h0011, 1);
        issue(0, C_ACT, 2'b11, 13'h1FFF, 1);
        check("R3 mask b", open_mask_o, 4'b1011);
        issue(0, C_PRE, 2'b11, 13'h0000, 1);
        check("R5 pre one", {cmd_o, bank_o, preall_o, open_mask_o}, {3'd4, 2'd3, 1'b0, 4'b0011});
        issue(0, C_PRE, 2'b10, 13'h0000, 1);
        check("R5 pre closed", {proto_err_o, open_mask_o}, {1'b0, 4'b0011});
        issue(0, C_PRE, 2'b00, 13'h0400, 1);
        check("R5 pre all", {preall_o, open_mask_o}, {1'b1, 4'b0000});
    endtask

    task automatic t_refresh();
        issue(0, C_REF, 2'b00, 13'h0000, 1);
        check("R1 ref", {cmd_vld_o, cmd_o}, {1'b1, 3'd5});
        issue(0, 3'b110, 2'b00, 13'h0000, 1);
        check("R1 code110", cmd_vld_o, 0);
        issue(0, 3'b000, 2'b00, 13'h0000, 1);
        check("R1 code000", cmd_vld_o, 0);
        issue(0, C_NOP, 2'b00, 13'h0000, 1);
        check("R1 nop", cmd_vld_o, 0);
    endtask

    task automatic t_power();
        issue(0, C_NOP, 2'b00, 13'h0000, 0);
        check("R9 pd enter", {pwrdn_o, selfref_o, cmd_vld_o}, 3'b100);
        issue(0, C_ACT, 2'b00, 13'h0005, 0);
        check("R10 pd no cmd", {cmd_vld_o, open_mask_o, cke_viol_o}, 6'b0);
        issue(0, C_ACT, 2'b00, 13'h0005, 1);
        check("R10 exit edge", {pwrdn_o, cmd_vld_o, open_mask_o}, 6'b0);
        check("R11 held ok", cke_viol_o, 0);
        issue(0, C_ACT, 2'b00, 13'h0005, 1);
        check("R10 resumed", {cmd_vld_o, open_mask_o}, {1'b1, 4'b0001});
        issue(0, C_REF, 2'b00, 13'h0000, 0);
        check("R9 sr enter", {selfref_o, pwrdn_o, cmd_vld_o}, 3'b100);
        issue(0, C_NOP, 2'b00, 13'h0000, 0);
        check("R9 sr hold", selfref_o, 1);
        issue(0, C_NOP, 2'b00, 13'h0000, 1);
        check("R9 sr exit", {selfref_o, pwrdn_o}, 2'b00);
    endtask

    task automatic t_viol();
        issue(0, C_NOP, 2'b00, 13'h0000, 1);
        issue(0, C_NOP, 2'b00, 13'h0000, 0);
        check("R11 no viol yet", {cke_viol_o, pwrdn_o}, 2'b01);
        issue(0, C_NOP, 2'b00, 13'h0000, 1);
        check("R11 viol", cke_viol_o, 1);
        issue(0, C_NOP, 2'b00, 13'h0000, 1);
        check("R11 viol clears", cke_viol_o, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_activate();
        t_rdwr();
        t_errors();
        t_autopre();
        t_precharge();
        t_refresh();
        t_power();
        t_viol();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule